// File: doc/BRIEF.md
# Super I/O configuration port

This block is the configuration front end of a legacy Super I/O controller. Host software reaches it through two byte-wide ports on an ISA-style bus: an index port at the strapped base address and a data port one address above it. After reset the port is locked. Software unlocks it by writing a fixed four-byte key to the index port. From then on, an index written to the index port picks the register that the data port reads or writes.

The register space has two regions. Below 0x30 are the global registers: chip identification, chip revision, the exit control and the logical-device selector. From 0x30 upward is a banked window onto the register file of the logical device picked by the selector. Each device holds an enable bit, a 16-bit I/O base and an interrupt line, and each has its own reset values. Writing the exit code locks the port again. The devices themselves are outside this block; it only holds their configuration.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked. While locked, `bus_rdata` is 0xFF at every address, and data-port writes change no register.
- R2: The port unlocks after four consecutive index-port writes of 0x87, 0x01, 0x55 and a last byte. The last byte is 0x55 when `BASE_PORT` is 0x002E and 0xAA for any other base. The other last byte does not unlock.
- R3: While locked, a wrong key byte returns the key tracker to its start. A wrong byte equal to 0x87 counts as the first key byte, so the sequence continues at its second byte.
- R4: While unlocked, a write to `BASE_PORT` sets the index, and reading `BASE_PORT` returns it. Reads and writes at `BASE_PORT`+1 reach the indexed register. Writes to any other address have no effect, and reads there give 0xFF.
- R5: Index 0x20 reads `ID_HI` (default 0x87), index 0x21 reads `ID_LO` (default 0x12), and index 0x22 reads `CHIP_REV` in bits 3..0 with bits 7..4 zero. Writes to these indices are ignored.
- R6: Writing data 0x02 at index 0x02 locks the port and clears the index to 0x00. Any other data at index 0x02 is ignored. Once locked, the key must be replayed, and register contents survive the lock.
- R7: Index 0x07 is a read/write 8-bit device selector that resets to 0. Each device's banked registers are separate storage.
- R8: Device reset values: device 0 has base 0x03F8 and IRQ 4; device 1 has base 0x02F8 and IRQ 3; device n≥2 has base 0x0100+0x20·n and IRQ n+5. All devices reset disabled. Index 0x60 holds base bits 15..8 and index 0x61 holds bits 7..0.
- R9: Index 0x30 stores only bit 0, the device enable, and reads bits 7..1 as zero. Index 0x70 stores only bits 3..0, the IRQ, and reads bits 7..4 as zero.
- R10: When the selector is `NUM_LDN` or above, every banked index reads 0xFF and banked writes are discarded. No implemented device is modified.
- R11: Indices 0x20–0x2F read the same whatever the selector holds. Unimplemented indices, global or banked, read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte for the current address (combinational) |

## Verification
The unlock tracker gets the exact key and the key with the wrong last byte on both base straps, which shows whether the strap picks the last byte. It also gets prefixes broken by a stray byte and by a repeated 0x87, which shows a full restart apart from a restart at step two. Directed accesses walk every device's reset values and then write one device and read its neighbours. They also use an out-of-range selector whose low bits alias an implemented device, which exposes any bank decode that ignores the upper selector bits. A long random mix of key bytes, indices, selector values and exit writes is compared, after every write, against a bench model of the register space.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   typedef enum logic [2:0] {
      KS_IDLE,
      KS_GOT1,
      KS_GOT2,
      KS_GOT3,
      KS_OPEN
   } key_state_e;

   localparam logic [7:0] KEY_B0       = 8'h87;
   localparam logic [7:0] KEY_B1       = 8'h01;
   localparam logic [7:0] KEY_B2       = 8'h55;
   localparam logic [7:0] KEY_LAST_PRI = 8'h55;
   localparam logic [7:0] KEY_LAST_ALT = 8'hAA;
   localparam logic [15:0] PRIMARY_BASE = 16'h002E;

   localparam logic [7:0] IDX_EXIT     = 8'h02;
   localparam logic [7:0] EXIT_CODE    = 8'h02;
   localparam logic [7:0] IDX_LDN      = 8'h07;
   localparam logic [7:0] IDX_ID_HI    = 8'h20;
   localparam logic [7:0] IDX_ID_LO    = 8'h21;
   localparam logic [7:0] IDX_REV      = 8'h22;
   localparam logic [7:0] IDX_BANK_LO  = 8'h30;
   localparam logic [7:0] IDX_ENABLE   = 8'h30;
   localparam logic [7:0] IDX_BASE_HI  = 8'h60;
   localparam logic [7:0] IDX_BASE_LO  = 8'h61;
   localparam logic [7:0] IDX_IRQ      = 8'h70;
   localparam logic [7:0] NO_DATA      = 8'hFF;

   function automatic logic [15:0] dev_base_default(int unsigned dev);
      if (dev == 0)
         return 16'h03F8;
      else if (dev == 1)
         return 16'h02F8;
      else
         return 16'h0100 + 16'(dev) * 16'h0020;
   endfunction

   function automatic logic [3:0] dev_irq_default(int unsigned dev);
      if (dev == 0)
         return 4'd4;
      else if (dev == 1)
         return 4'd3;
      else
         return 4'(dev + 5);
   endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] KEY_LAST = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       exit_req,
   output logic       unlocked
);

   key_state_e state_q, state_d, adv;
   logic [7:0] want;

   // byte expected in each step and the step it leads to
   always_comb begin
      want = KEY_B0;
      adv  = KS_GOT1;
      case (state_q)
         KS_GOT1: begin want = KEY_B1;   adv = KS_GOT2; end
         KS_GOT2: begin want = KEY_B2;   adv = KS_GOT3; end
         KS_GOT3: begin want = KEY_LAST; adv = KS_OPEN; end
         default: ;
      endcase
   end

   always_comb begin
      state_d = state_q;
      if (state_q == KS_OPEN) begin
         if (exit_req)
            state_d = KS_IDLE;
      end else if (key_wr) begin
         if (key_byte == want)
            state_d = adv;
         else if (key_byte == KEY_B0)
            state_d = KS_GOT1;
         else
            state_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= KS_IDLE;
      else
         state_q <= state_d;
   end

   assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] ID_HI    = 8'h87,
   parameter logic [7:0] ID_LO    = 8'h12,
   parameter logic [3:0] CHIP_REV = 4'h8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] ldn,
   output logic [7:0] rdata
);

   logic [7:0] ldn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ldn_q <= 8'h00;
      else if (wr_en && idx == IDX_LDN)
         ldn_q <= wdata;
   end

   always_comb begin
      case (idx)
         IDX_LDN:   rdata = ldn_q;
         IDX_ID_HI: rdata = ID_HI;
         IDX_ID_LO: rdata = ID_LO;
         IDX_REV:   rdata = {4'h0, CHIP_REV};
         default:   rdata = NO_DATA;
      endcase
   end

   assign ldn = ldn_q;

endmodule

// File: rtl/sio_ldn_dev.sv
module sio_ldn_dev
   import sio_cfg_pkg::*;
#(
   parameter int unsigned DEV_NUM = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   localparam logic [15:0] RST_BASE = dev_base_default(DEV_NUM);
   localparam logic [3:0]  RST_IRQ  = dev_irq_default(DEV_NUM);

   logic        en_q;
   logic [15:0] base_q;
   logic [3:0]  irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= RST_BASE;
         irq_q  <= RST_IRQ;
      end else if (wr_en) begin
         case (idx)
            IDX_ENABLE:  en_q         <= wdata[0];
            IDX_BASE_HI: base_q[15:8] <= wdata;
            IDX_BASE_LO: base_q[7:0]  <= wdata;
            IDX_IRQ:     irq_q        <= wdata[3:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IDX_ENABLE:  rdata = {7'b0, en_q};
         IDX_BASE_HI: rdata = base_q[15:8];
         IDX_BASE_LO: rdata = base_q[7:0];
         IDX_IRQ:     rdata = {4'h0, irq_q};
         default:     rdata = NO_DATA;
      endcase
   end

endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank
   import sio_cfg_pkg::*;
#(
   parameter int unsigned NUM_LDN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   input  logic [7:0] ldn,
   output logic [7:0] rdata
);

   localparam int unsigned LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

   logic       ldn_ok;
   logic [7:0] dev_rdata [NUM_LDN];

   assign ldn_ok = ({1'b0, ldn} < 9'(NUM_LDN));

   for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
      sio_ldn_dev #(
         .DEV_NUM (g)
      ) u_dev (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_en && (ldn == 8'(g))),
         .idx   (idx),
         .wdata (wdata),
         .rdata (dev_rdata[g])
      );
   end

   assign rdata = ldn_ok ? dev_rdata[ldn[LDN_W-1:0]] : NO_DATA;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter logic [15:0] BASE_PORT = 16'h002E,
   parameter int unsigned NUM_LDN   = 4,
   parameter logic [7:0]  ID_HI     = 8'h87,
   parameter logic [7:0]  ID_LO     = 8'h12,
   parameter logic [3:0]  CHIP_REV  = 4'h8,
   parameter int unsigned ADDR_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);

   localparam logic [ADDR_W-1:0] IDX_PORT = BASE_PORT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] DAT_PORT = IDX_PORT + ADDR_W'(1);

   if (NUM_LDN < 1 || NUM_LDN > 16) begin : g_bad_num_ldn
      $error("sio_cfg_port: NUM_LDN must lie in 1..16");
   end
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
      $error("sio_cfg_port: ADDR_W must lie in 8..16");
   end
   if (BASE_PORT[0] != 1'b0) begin : g_bad_base
      $error("sio_cfg_port: BASE_PORT must be even");
   end

   logic       hit_idx, hit_dat;
   logic       unlocked;
   logic       key_wr, idx_wr, dat_wr, exit_req;
   logic [7:0] idx_q;
   logic [7:0] ldn;
   logic [7:0] glb_rdata, bank_rdata;

   assign hit_idx  = (bus_addr == IDX_PORT);
   assign hit_dat  = (bus_addr == DAT_PORT);
   assign key_wr   = bus_wr && hit_idx && !unlocked;
   assign idx_wr   = bus_wr && hit_idx && unlocked;
   assign dat_wr   = bus_wr && hit_dat && unlocked;
   assign exit_req = dat_wr && (idx_q == IDX_EXIT) && (bus_wdata == EXIT_CODE);

   // the strap decides which last key byte the tracker accepts
   if (BASE_PORT == PRIMARY_BASE) begin : g_key_primary
      sio_key_fsm #(
         .KEY_LAST (KEY_LAST_PRI)
      ) u_key (
         .clk      (clk),
         .rst_n    (rst_n),
         .key_wr   (key_wr),
         .key_byte (bus_wdata),
         .exit_req (exit_req),
         .unlocked (unlocked)
      );
   end else begin : g_key_alt
      sio_key_fsm #(
         .KEY_LAST (KEY_LAST_ALT)
      ) u_key (
         .clk      (clk),
         .rst_n    (rst_n),
         .key_wr   (key_wr),
         .key_byte (bus_wdata),
         .exit_req (exit_req),
         .unlocked (unlocked)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= 8'h00;
      else if (exit_req)
         idx_q <= 8'h00;
      else if (idx_wr)
         idx_q <= bus_wdata;
   end

   sio_global_regs #(
      .ID_HI    (ID_HI),
      .ID_LO    (ID_LO),
      .CHIP_REV (CHIP_REV)
   ) u_glb (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_wr),
      .idx   (idx_q),
      .wdata (bus_wdata),
      .ldn   (ldn),
      .rdata (glb_rdata)
   );

   sio_ldn_bank #(
      .NUM_LDN (NUM_LDN)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_wr && (idx_q >= IDX_BANK_LO)),
      .idx   (idx_q),
      .wdata (bus_wdata),
      .ldn   (ldn),
      .rdata (bank_rdata)
   );

   always_comb begin
      if (!unlocked)
         bus_rdata = NO_DATA;
      else if (hit_idx)
         bus_rdata = idx_q;
      else if (hit_dat)
         bus_rdata = (idx_q < IDX_BANK_LO) ? glb_rdata : bank_rdata;
      else
         bus_rdata = NO_DATA;
   end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter logic [15:0] BASE_PORT = 16'h002E,
   parameter int unsigned NUM_LDN   = 4,
   parameter logic [7:0]  ID_HI     = 8'h87,
   parameter int unsigned ADDR_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              unlocked,
   input logic [7:0]        idx_q,
   input logic [7:0]        ldn
);

   localparam logic [ADDR_W-1:0] IDXP = BASE_PORT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] DATP = IDXP + ADDR_W'(1);
   localparam logic [7:0] LAST = (BASE_PORT == 16'h002E) ? 8'h55 : 8'hAA;

   assert_locked_reads_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> bus_rdata == 8'hFF);

   assert_unlock_after_last_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(bus_wr && bus_addr == IDXP && bus_wdata == LAST));

   assert_id_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked && bus_addr == DATP && idx_q == 8'h20 |-> bus_rdata == ID_HI);

   assert_exit_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked && bus_wr && bus_addr == DATP && idx_q == 8'h02 && bus_wdata == 8'h02
      |=> !unlocked);

   assert_locked_keeps_ldn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked && bus_wr && bus_addr == DATP |=> $stable(ldn));

   assert_ldn_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked && bus_wr && bus_addr == DATP && idx_q == 8'h07
      |=> ldn == $past(bus_wdata));

   assert_ldn_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked && bus_addr == DATP && idx_q >= 8'h30 && {1'b0, ldn} >= 9'(NUM_LDN)
      |-> bus_rdata == 8'hFF);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .BASE_PORT (BASE_PORT),
   .NUM_LDN   (NUM_LDN),
   .ID_HI     (ID_HI),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .unlocked  (unlocked),
   .idx_q     (idx_q),
   .ldn       (ldn)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;

   localparam int NDEV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata, b_rdata;

   int checks = 0;
   int failures = 0;

   // bench model of the unit at base 0x2E
   int         m_st;
   logic [7:0] m_idx, m_ldn;
   logic       m_en   [NDEV];
   logic [15:0] m_base [NDEV];
   logic [3:0] m_irq  [NDEV];

   always #10 clk = ~clk;

   sio_cfg_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   sio_cfg_port #(.BASE_PORT(16'h004E)) dut_b (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(b_rdata));

   function automatic logic [15:0] def_base(int d);
      if (d == 0) return 16'h03F8;
      if (d == 1) return 16'h02F8;
      return 16'h0100 + 16'(d * 32);
   endfunction

   function automatic logic [3:0] def_irq(int d);
      if (d == 0) return 4'd4;
      if (d == 1) return 4'd3;
      return 4'(d + 5);
   endfunction

   function automatic int key_next(int st, logic [7:0] d);
      logic [7:0] want;
      want = (st == 0) ? 8'h87 : (st == 1) ? 8'h01 : (st == 2) ? 8'h55 : 8'h55;
      if (d == want) return st + 1;
      if (d == 8'h87) return 1;
      return 0;
   endfunction

   function automatic logic [7:0] key_byte_for(int st);
      return (st == 0) ? 8'h87 : (st == 1) ? 8'h01 : 8'h55;
   endfunction

   function automatic logic [7:0] exp_rd(logic [15:0] a);
      int d;
      if (m_st != 4) return 8'hFF;
      if (a == 16'h002E) return m_idx;
      if (a != 16'h002F) return 8'hFF;
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return 8'h87;
         8'h21: return 8'h12;
         8'h22: return 8'h08;
         default: ;
      endcase
      if (m_idx < 8'h30 || m_ldn >= 8'(NDEV)) return 8'hFF;
      d = int'(m_ldn);
      case (m_idx)
         8'h30: return {7'b0, m_en[d]};
         8'h60: return m_base[d][15:8];
         8'h61: return m_base[d][7:0];
         8'h70: return {4'h0, m_irq[d]};
         default: return 8'hFF;
      endcase
   endfunction

   task automatic model_reset();
      m_st = 0; m_idx = 8'h00; m_ldn = 8'h00;
      for (int d = 0; d < NDEV; d++) begin
         m_en[d] = 1'b0; m_base[d] = def_base(d); m_irq[d] = def_irq(d);
      end
   endtask

   task automatic model_wr(logic [15:0] a, logic [7:0] v);
      int d;
      if (a == 16'h002E) begin
         if (m_st != 4) m_st = key_next(m_st, v);
         else m_idx = v;
      end else if (a == 16'h002F && m_st == 4) begin
         if (m_idx == 8'h02 && v == 8'h02) begin
            m_st = 0; m_idx = 8'h00;
         end else if (m_idx == 8'h07) begin
            m_ldn = v;
         end else if (m_idx >= 8'h30 && m_ldn < 8'(NDEV)) begin
            d = int'(m_ldn);
            case (m_idx)
               8'h30: m_en[d] = v[0];
               8'h60: m_base[d][15:8] = v;
               8'h61: m_base[d][7:0] = v;
               8'h70: m_irq[d] = v[3:0];
               default: ;
            endcase
         end
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      model_wr(a, v);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd_chk(string req, logic [15:0] a);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_rd(a));
   endtask

   task automatic rd_b(string req, logic [15:0] a, logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(req, b_rdata, exp);
   endtask

   task automatic key(logic [15:0] a, logic [7:0] b0, logic [7:0] b1,
                      logic [7:0] b2, logic [7:0] b3);
      wr(a, b0); wr(a, b1); wr(a, b2); wr(a, b3);
   endtask

   task automatic sel(logic [7:0] i, logic [7:0] v);
      wr(16'h002E, i); wr(16'h002F, v);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int unsigned r;
      logic [7:0] v;
      logic [15:0] a;
      logic [7:0] idx_tab [12];
      idx_tab = '{8'h02, 8'h07, 8'h20, 8'h21, 8'h22, 8'h30,
                  8'h60, 8'h61, 8'h70, 8'h45, 8'h28, 8'h7F};
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset and locked behaviour
      rd_chk("R1 locked data", 16'h002F);
      rd_chk("R1 locked index", 16'h002E);
      wr(16'h002F, 8'h33);
      rd_b("R1 alt locked", 16'h004F, 8'hFF);

      // R3 broken prefix, then restart at step two
      key(16'h002E, 8'h87, 8'h01, 8'h00, 8'h55);
      wr(16'h002E, 8'h55);
      rd_chk("R3 stray byte keeps lock", 16'h002E);
      chk("R3 model locked", bus_rdata, 8'hFF);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h87);
      wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
      wr(16'h002E, 8'h20);
      rd_chk("R3 restart at step two", 16'h002F);
      chk("R3 unlocked id", bus_rdata, 8'h87);

      // R2 alternate strap
      key(16'h004E, 8'h87, 8'h01, 8'h55, 8'h55);
      rd_b("R2 alt rejects 0x55", 16'h004F, 8'hFF);
      key(16'h004E, 8'h87, 8'h01, 8'h55, 8'hAA);
      wr(16'h004E, 8'h20);
      rd_b("R2 alt accepts 0xAA", 16'h004F, 8'h87);
      rd_chk("R4 main ignores alt port", 16'h002E);

      // R5 id registers, writes ignored
      sel(8'h20, 8'h00);
      rd_chk("R5 id high", 16'h002F);
      sel(8'h21, 8'hFF);
      rd_chk("R5 id low", 16'h002F);
      chk("R5 id low value", bus_rdata, 8'h12);
      sel(8'h22, 8'hFF);
      rd_chk("R5 revision", 16'h002F);
      chk("R5 revision value", bus_rdata, 8'h08);

      // R1: data write while locked earlier did not reach selector
      wr(16'h002E, 8'h07);
      rd_chk("R1 locked write dropped", 16'h002F);
      chk("R7 selector reset", bus_rdata, 8'h00);

      // R8 defaults for every device
      for (int d = 0; d < NDEV; d++) begin
         sel(8'h07, 8'(d));
         wr(16'h002E, 8'h60); rd_chk("R8 base high", 16'h002F);
         wr(16'h002E, 8'h61); rd_chk("R8 base low", 16'h002F);
         wr(16'h002E, 8'h70); rd_chk("R8 irq", 16'h002F);
         wr(16'h002E, 8'h30); rd_chk("R8 disabled", 16'h002F);
      end
      sel(8'h07, 8'h00); wr(16'h002E, 8'h60);
      rd_chk("R8 dev0 base high", 16'h002F);
      chk("R8 dev0 base high value", bus_rdata, 8'h03);

      // R9 field widths
      sel(8'h07, 8'h02);
      sel(8'h30, 8'hFE); rd_chk("R9 enable bit0 only", 16'h002F);
      sel(8'h30, 8'hFF); rd_chk("R9 enable set", 16'h002F);
      chk("R9 enable value", bus_rdata, 8'h01);
      sel(8'h70, 8'hF7); rd_chk("R9 irq nibble", 16'h002F);
      chk("R9 irq value", bus_rdata, 8'h07);

      // R7 separate banks
      sel(8'h60, 8'hAB);
      sel(8'h07, 8'h01); wr(16'h002E, 8'h60);
      rd_chk("R7 neighbour untouched", 16'h002F);
      chk("R7 neighbour value", bus_rdata, 8'h02);
      sel(8'h07, 8'h02); wr(16'h002E, 8'h60);
      rd_chk("R7 written bank", 16'h002F);

      // R10 out-of-range selector aliasing device 1
      sel(8'h07, 8'h09);
      sel(8'h60, 8'h11); rd_chk("R10 banked ff", 16'h002F);
      sel(8'h30, 8'h01); rd_chk("R10 enable ff", 16'h002F);
      // R11 globals ignore selector, unimplemented read ff
      wr(16'h002E, 8'h20); rd_chk("R11 global with bad ldn", 16'h002F);
      wr(16'h002E, 8'h28); rd_chk("R11 unimplemented global", 16'h002F);
      sel(8'h07, 8'h01);
      wr(16'h002E, 8'h45); rd_chk("R11 unimplemented banked", 16'h002F);
      wr(16'h002E, 8'h60); rd_chk("R10 alias not written", 16'h002F);
      wr(16'h002E, 8'h30); rd_chk("R10 alias enable", 16'h002F);

      // R4 stray addresses
      wr(16'h002D, 8'h07); wr(16'h0030, 8'h55);
      rd_chk("R4 other address", 16'h0030);
      rd_chk("R4 index port readback", 16'h002E);

      // R6 exit
      sel(8'h02, 8'h01); rd_chk("R6 other code ignored", 16'h002E);
      sel(8'h02, 8'h02);
      rd_chk("R6 locked after exit", 16'h002F);
      wr(16'h002F, 8'h05);
      key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
      rd_chk("R6 index cleared", 16'h002E);
      wr(16'h002E, 8'h07); rd_chk("R6 state kept", 16'h002F);

      // random mix against the model
      r = $urandom(32'd2024);
      for (int i = 0; i < 4000; i++) begin
         r = $urandom;
         if (r[2:0] < 3'd4) begin
            a = 16'h002E;
            if (m_st != 4)
               v = (r[7:4] < 4'd10) ? key_byte_for(m_st)
                  : ((r[9:8] == 2'd0) ? 8'h87 : 8'(r >> 16));
            else
               v = idx_tab[(r >> 8) % 12];
         end else if (r[2:0] < 3'd7) begin
            a = 16'h002F;
            if (m_idx == 8'h07) v = 8'((r >> 8) % 6);
            else if (m_idx == 8'h02) v = r[8] ? 8'h02 : 8'(r >> 16);
            else v = 8'(r >> 16);
         end else begin
            a = 16'h004F;
            v = 8'(r >> 16);
         end
         wr(a, v);
         rd_chk("R7 random data", 16'h002F);
         if (r[20]) rd_chk("R4 random index", 16'h002E);
      end

      finish_run();
   end

endmodule